// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block connects a small register interface on the system side to a three-wire serial EEPROM. Software loads a 16-bit command word and, if needed, a 16-bit word of write data. It then starts an operation by writing a one-hot code to the control register. The controller clocks the command out, most significant bit first. Depending on the operation, it then shifts the data word out, or it shifts 16 bits in. For writes, it also releases chip select, asserts it again and waits until the memory reports that it is ready.

Read data lands in a buffer that is separate from the write buffer, and that buffer only changes when a read finishes. A status register shows three things: whether the controller is idle, whether the last read has completed, and the state of a write-protection latch. Once the latch is set, only reset clears it. While it is set, the controller refuses any write or erase aimed at word address 0x30 or above, and it also refuses the whole-array write and whole-array erase.

Top module: `mwc_top`

## Requirements
- R1: A write to the control register (select 2) starts an operation only when exactly one of data bits 4 (read), 5 (write), 6 (short) or 7 (protect) is 1.
- R2: A control write with more than one of bits 7:4 set causes no serial activity and leaves the protection latch unchanged (0x90 does not protect, 0x80 does).
- R3: The protection latch, shown in status bit 7, clears only on reset.
- R4: A read clocks out the 16 command bits MSB first, then clocks in 16 bits MSB first into the read buffer (select 0 read). Status bit 0 is 0 from the start of the read until it completes, then returns to 1.
- R5: A write clocks out the command and then the write data, 32 bits in all. It then drops chip select, raises it with no clocks and waits until data-in is 1. Status bit 1 stays 0 from start to finish.
- R6: A short operation clocks out the 16 command bits and drops chip select.
- R7: Write data is captured when the write starts. Bus writes to the write buffer (select 0 write) during the operation do not change the bits sent.
- R8: The read buffer and status bit 0 are unchanged by writes to the write buffer and by write or short operations.
- R9: The command register (select 1) reads back its last written value, whatever is written to the control register.
- R10: With protection set, write or short operations are suppressed with no serial activity when the command opcode (bits 7:6) is 01 or 11 at an address (bits 5:0) of 0x30 or above, or when the opcode is 00 with sub-opcode (bits 5:4) 01 or 10. Other commands still run.
- R11: The serial clock stays high for CLK_DIV system clocks, and data-out changes only when the serial clock falls or chip select changes.
- R12: Control writes made while busy are ignored.
- R13: After reset, chip select and serial clock are low and status reads 0x0003.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| regSel | input | 2 | Register select: 0 data, 1 command, 2 control/status |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for the selected register |
| mwCs | output | 1 | Serial chip select, active high |
| mwSk | output | 1 | Serial clock |
| mwDo | output | 1 | Serial data to the EEPROM |
| mwDi | input | 1 | Serial data from the EEPROM |

## Verification
The bench runs each of the three operation kinds and records every chip-select frame as a bit count plus the bits captured on rising clocks. This tells a read frame (32 clocks, 16 out) apart from a write frame (32 out, followed by a frame with no clocks while polling) and from a short frame (16 clocks). Multi-bit control codes, and protected commands on both sides of the 0x30 boundary, must produce no frame at all. Changing the write buffer and issuing a control write while busy separate captured data from live register contents. A reset in the middle of the run checks that the protection latch is cleared.

// File: rtl/mwc_pkg.sv
package mwc_pkg;
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam logic [3:0] OP_READ    = 4'b0001;
  localparam logic [3:0] OP_WRITE   = 4'b0010;
  localparam logic [3:0] OP_SHORT   = 4'b0100;
  localparam logic [3:0] OP_PROTECT = 4'b1000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_RECV, ST_GAP, ST_POLL, ST_TAIL
  } mwState_t;

  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic sampleRx;
    logic commitRx;
    logic rdStart;
  } mwStrobe_t;
endpackage

// File: rtl/mwc_datapath.sv
module mwc_datapath
  import mwc_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        regSel,
  input  logic              regWrEn,
  input  logic [WORD_W-1:0] regWrData,
  input  logic              ctlWr,
  input  logic              busy,
  input  mwStrobe_t         strb,
  input  logic              mwDi,
  output logic [WORD_W-1:0] regRdData,
  output logic [WORD_W-1:0] cmdWord,
  output logic              protOn,
  output logic              txBit
);
  localparam int FRAME_W = 2 * WORD_W;

  logic [WORD_W-1:0]  cmdReg, wrBuf, rdBuf, rxShift, statusWord;
  logic [FRAME_W-1:0] txShift;
  logic               rdDone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdReg <= '0;
      wrBuf  <= '0;
    end else if (regWrEn) begin
      if (regSel == SEL_CMD)  cmdReg <= regWrData;
      if (regSel == SEL_DATA) wrBuf  <= regWrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) protOn <= 1'b0;
    else if (ctlWr && !busy && regWrData[7:4] == OP_PROTECT) protOn <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txShift <= '0;
    else if (strb.loadTx) txShift <= {cmdReg, wrBuf};
    else if (strb.shiftTx) txShift <= {txShift[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift <= '0;
      rdBuf   <= '0;
      rdDone  <= 1'b1;
    end else begin
      if (strb.sampleRx) rxShift <= {rxShift[WORD_W-2:0], mwDi};
      if (strb.commitRx) begin
        rdBuf  <= rxShift;
        rdDone <= 1'b1;
      end else if (strb.rdStart) begin
        rdDone <= 1'b0;
      end
    end
  end

  always_comb begin
    statusWord    = '0;
    statusWord[7] = protOn;
    statusWord[1] = !busy;
    statusWord[0] = rdDone;
    case (regSel)
      SEL_DATA: regRdData = rdBuf;
      SEL_CMD:  regRdData = cmdReg;
      SEL_CTRL: regRdData = statusWord;
      default:  regRdData = '0;
    endcase
  end

  assign cmdWord = cmdReg;
  assign txBit   = txShift[FRAME_W-1];

  // R3
  prot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    protOn |=> protOn);
  // R8
  rdbuf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.commitRx |=> $stable(rdBuf));
  // R7
  txshift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.loadTx && !strb.shiftTx |=> $stable(txShift));
  // R4
  rd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commitRx |=> rdDone);
endmodule

// File: rtl/mwc_control.sv
module mwc_control
  import mwc_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int ADDR_W     = 6,
  parameter int CLK_DIV    = 4,
  parameter int PROT_LIMIT = 'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctlWr,
  input  logic [3:0]        opField,
  input  logic [WORD_W-1:0] cmdWord,
  input  logic              protOn,
  input  logic              mwDi,
  output mwStrobe_t         strb,
  output logic              busy,
  output logic              mwCs,
  output logic              mwSk
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int CNT_W = $clog2(2 * WORD_W);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] SHORT_END = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LONG_END  = CNT_W'(2 * WORD_W - 1);

  mwState_t         state;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             isRead, isWrite;
  logic             tick, touchesProt, startRd, startWr, startSh, lastBit;
  logic [1:0]       opcode, subOp;
  logic [ADDR_W-1:0] wordAddr;

  assign opcode   = cmdWord[ADDR_W+1:ADDR_W];
  assign subOp    = cmdWord[ADDR_W-1:ADDR_W-2];
  assign wordAddr = cmdWord[ADDR_W-1:0];

  always_comb begin
    touchesProt = 1'b0;
    if ((opcode == 2'b01 || opcode == 2'b11) && wordAddr >= ADDR_W'(PROT_LIMIT))
      touchesProt = 1'b1;
    if (opcode == 2'b00 && (subOp == 2'b01 || subOp == 2'b10))
      touchesProt = 1'b1;
  end

  assign busy    = (state != ST_IDLE);
  assign startRd = ctlWr && !busy && opField == OP_READ;
  assign startWr = ctlWr && !busy && opField == OP_WRITE && !(protOn && touchesProt);
  assign startSh = ctlWr && !busy && opField == OP_SHORT && !(protOn && touchesProt);
  assign tick    = busy && divCnt == DIV_LAST;
  assign lastBit = (state == ST_SEND) ? (bitCnt == (isWrite ? LONG_END : SHORT_END))
                                      : (bitCnt == SHORT_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      bitCnt  <= '0;
      mwSk    <= 1'b0;
      isRead  <= 1'b0;
      isWrite <= 1'b0;
    end else begin
      if (!busy || tick) divCnt <= '0;
      else divCnt <= divCnt + 1'b1;
      case (state)
        ST_IDLE: begin
          mwSk   <= 1'b0;
          bitCnt <= '0;
          if (startRd || startWr || startSh) begin
            state   <= ST_SEND;
            isRead  <= startRd;
            isWrite <= startWr;
          end
        end
        ST_SEND, ST_RECV: begin
          if (tick) begin
            if (!mwSk) mwSk <= 1'b1;
            else begin
              mwSk <= 1'b0;
              if (lastBit) begin
                bitCnt <= '0;
                if (state == ST_RECV) state <= ST_TAIL;
                else if (isRead)      state <= ST_RECV;
                else if (isWrite)     state <= ST_GAP;
                else                  state <= ST_TAIL;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end
        end
        ST_GAP:  if (tick) state <= ST_POLL;
        ST_POLL: if (tick && mwDi) state <= ST_TAIL;
        ST_TAIL: if (tick) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.loadTx   = startRd || startWr || startSh;
    strb.rdStart  = startRd;
    strb.shiftTx  = (state == ST_SEND) && tick && mwSk;
    strb.sampleRx = (state == ST_RECV) && tick && !mwSk;
    strb.commitRx = (state == ST_RECV) && tick && mwSk && lastBit;
  end

  assign mwCs = (state == ST_SEND) || (state == ST_RECV) || (state == ST_POLL);

  // R12
  no_restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !strb.loadTx);
  // R10
  prot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadTx && protOn && !strb.rdStart |-> !touchesProt);
  // R5
  poll_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POLL) && ($past(state) != ST_POLL) |-> $past(state) == ST_GAP);
  // R1
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadTx |-> ctlWr && $onehot0(opField));
endmodule

// File: rtl/mwc_top.sv
module mwc_top
  import mwc_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int ADDR_W     = 6,
  parameter int CLK_DIV    = 4,
  parameter int PROT_LIMIT = 'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        regSel,
  input  logic              regWrEn,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  output logic              mwCs,
  output logic              mwSk,
  output logic              mwDo,
  input  logic              mwDi
);
  mwStrobe_t         strb;
  logic              busy, protOn, txBit, ctlWr;
  logic [WORD_W-1:0] cmdWord;

  assign ctlWr = regWrEn && (regSel == SEL_CTRL);

  mwc_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .ctlWr(ctlWr), .busy(busy), .strb(strb),
    .mwDi(mwDi), .regRdData(regRdData), .cmdWord(cmdWord),
    .protOn(protOn), .txBit(txBit)
  );

  mwc_control #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CLK_DIV(CLK_DIV),
                .PROT_LIMIT(PROT_LIMIT)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctlWr(ctlWr), .opField(regWrData[7:4]),
    .cmdWord(cmdWord), .protOn(protOn), .mwDi(mwDi), .strb(strb),
    .busy(busy), .mwCs(mwCs), .mwSk(mwSk)
  );

  assign mwDo = txBit && mwCs;

  // R11
  do_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mwCs && $past(mwCs) && !($past(mwSk) && !mwSk) |-> $stable(mwDo));
endmodule

// File: tb/sim_mwc_top.sv
module sim_mwc_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  typedef struct packed {
    logic [5:0]  n;
    logic [31:0] word;
    logic [31:0] mask;
  } frame_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        mwCs, mwSk, mwDo, mwDi;
  logic        diRx = 1'b0, diPoll = 1'b0;

  int nChecks = 0, nFail = 0;
  frame_t expQ[$];

  int          nRise = 0;
  logic [31:0] bits = '0;
  logic        skBad = 1'b0, rxSeen = 1'b0, rxOn = 1'b0, pollPending = 1'b0;
  int          rxIdx = -1;
  logic [15:0] resp = '0;
  time         tRise = 0;

  assign mwDi = diRx | diPoll;

  mwc_top #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .mwCs(mwCs),
    .mwSk(mwSk), .mwDo(mwDo), .mwDi(mwDi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  // Slave model and frame monitor
  always @(posedge mwCs) begin
    nRise = 0; bits = '0; skBad = 1'b0; rxSeen = 1'b0;
  end

  always @(posedge mwSk) if (mwCs) begin
    tRise = $time;
    bits = {bits[30:0], mwDo};
    nRise++;
    if (nRise == 16 && bits[15:8] == 8'h01 && bits[7:6] == 2'b10) begin
      rxOn = 1'b1; rxIdx = 15; rxSeen = 1'b1;
    end
  end

  always @(negedge mwSk) if (mwCs) begin
    if (($time - tRise) != DIV * CLK_PERIOD) skBad = 1'b1;
    if (rxOn && rxIdx >= 0) begin
      diRx = resp[rxIdx];
      rxIdx--;
    end
  end

  always @(negedge mwCs) begin
    frame_t e;
    rxOn = 1'b0; diRx = 1'b0; diPoll = 1'b0;
    if (nRise == 32 && !rxSeen) pollPending = 1'b1;
    if (expQ.size() == 0) begin
      chk(1'b0, "R2/R10 unexpected frame", {26'd0, nRise[5:0]}, 32'd0);
    end else begin
      e = expQ.pop_front();
      chk(nRise == int'(e.n), "R4/R5/R6 frame length", nRise, {26'd0, e.n});
      chk((bits & e.mask) == (e.word & e.mask), "R4/R5/R6/R7 frame bits", bits & e.mask, e.word & e.mask);
      if (nRise > 0) chk(!skBad, "R11 serial clock high width", {31'd0, skBad}, 32'd0);
    end
  end

  always @(posedge mwCs) if (pollPending) begin
    pollPending = 1'b0;
    repeat (30) @(posedge clk);
    if (mwCs) diPoll = 1'b1;
  end

  // Driver tasks
  task automatic wrReg(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    regSel = sel; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] sel, output logic [15:0] d);
    @(negedge clk);
    regSel = sel;
    #1 d = regRdData;
  endtask

  task automatic waitIdle();
    logic [15:0] s;
    s = '0;
    while (!s[1]) rdReg(2'd2, s);
  endtask

  task automatic doRead(input logic [15:0] cmd, input logic [15:0] data);
    logic [15:0] s;
    resp = data;
    expQ.push_back('{6'd32, {cmd, 16'h0}, 32'hFFFF0000});
    wrReg(2'd1, cmd);
    wrReg(2'd2, 16'h0010);
    rdReg(2'd2, s);
    chk(s[1:0] == 2'b00, "R4 status during read", {16'd0, s}, 32'h0);
    waitIdle();
    rdReg(2'd0, s);
    chk(s == data, "R4 read buffer", {16'd0, s}, {16'd0, data});
    rdReg(2'd2, s);
    chk(s[0], "R4 read done bit", {16'd0, s}, 32'h1);
  endtask

  task automatic doWrite(input logic [15:0] cmd, input logic [15:0] data);
    expQ.push_back('{6'd32, {cmd, data}, 32'hFFFFFFFF});
    expQ.push_back('{6'd0, 32'h0, 32'h0});
    wrReg(2'd0, data);
    wrReg(2'd1, cmd);
    wrReg(2'd2, 16'h0020);
  endtask

  task automatic doShort(input logic [15:0] cmd);
    expQ.push_back('{6'd16, {16'h0, cmd}, 32'h0000FFFF});
    wrReg(2'd1, cmd);
    wrReg(2'd2, 16'h0040);
    waitIdle();
  endtask

  task automatic blocked(input logic [15:0] cmd, input logic [15:0] ctl, input string tag);
    logic [15:0] s;
    wrReg(2'd1, cmd);
    wrReg(2'd2, ctl);
    rdReg(2'd2, s);
    chk(s[1] && !mwCs, tag, {15'd0, mwCs, s}, 32'h2);
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    finishUp();
  end

  initial begin
    logic [15:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    rdReg(2'd2, s);
    chk(s == 16'h0003, "R13 status after reset", {16'd0, s}, 32'h3);
    chk(!mwCs && !mwSk, "R13 serial idle", {30'd0, mwCs, mwSk}, 32'h0);

    // R9 command readback, R2 multi-bit control
    wrReg(2'd1, 16'h1234);
    wrReg(2'd2, 16'h0090);
    rdReg(2'd1, s);
    chk(s == 16'h1234, "R9 command readback", {16'd0, s}, 32'h1234);
    rdReg(2'd2, s);
    chk(s == 16'h0003, "R2 0x90 not protecting", {16'd0, s}, 32'h3);
    wrReg(2'd2, 16'h0070);
    rdReg(2'd2, s);
    chk(s == 16'h0003 && !mwCs, "R1 multi-bit code discarded", {16'd0, s}, 32'h3);

    // R4 reads with two patterns
    doRead(16'h0185, 16'hA5C3);
    doRead(16'h01A2, 16'h5A01);

    // R5/R7/R12 write; change buffer and issue control while busy
    doWrite(16'h0147, 16'hBEEF);
    rdReg(2'd2, s);
    chk(s[1] == 1'b0, "R5 busy during write", {16'd0, s}, 32'h0);
    wrReg(2'd0, 16'h0000);
    wrReg(2'd2, 16'h0010);
    waitIdle();
    rdReg(2'd2, s);
    chk(s[0], "R12 control while busy ignored", {16'd0, s}, 32'h1);
    rdReg(2'd0, s);
    chk(s == 16'h5A01, "R8 read buffer after write", {16'd0, s}, 32'h5A01);

    // R6 short erase; R8 buffer untouched
    doShort(16'h01C9);
    wrReg(2'd0, 16'h7777);
    rdReg(2'd0, s);
    chk(s == 16'h5A01, "R8 read buffer after short", {16'd0, s}, 32'h5A01);

    // R3 protect
    wrReg(2'd2, 16'h0080);
    rdReg(2'd2, s);
    chk(s == 16'h0083, "R3 protect set", {16'd0, s}, 32'h83);
    wrReg(2'd2, 16'h0000);
    rdReg(2'd2, s);
    chk(s[7], "R3 protect sticky", {16'd0, s}, 32'h83);
    rdReg(2'd1, s);
    chk(s == 16'h01C9, "R9 command unaffected by control", {16'd0, s}, 32'h01C9);

    // R10 suppressed commands
    blocked(16'h0170, 16'h0020, "R10 write at 0x30 blocked");
    blocked(16'h01F5, 16'h0040, "R10 erase at 0x35 blocked");
    blocked(16'h0110, 16'h0020, "R10 write-all blocked");
    blocked(16'h0120, 16'h0040, "R10 erase-all blocked");
    // R10 allowed commands
    doWrite(16'h016F, 16'h1357);
    waitIdle();
    doShort(16'h0130);
    doRead(16'h01BF, 16'hC0DE);

    // R3 reset clears protection
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rdReg(2'd2, s);
    chk(s == 16'h0003, "R3 protect cleared by reset", {16'd0, s}, 32'h3);

    repeat (50) @(negedge clk);
    chk(expQ.size() == 0, "R10 all expected frames seen", expQ.size(), 32'd0);
    finishUp();
  end
endmodule